// File: doc/BRIEF.md
# Event Counter Register Bank

A bank of hardware event counters behind a 64-bit register read/write port. Each counter has a configuration register, a filter value register and a count register. The bank also holds one constant capability word, a small set of constant event-capability words, a shared overflow status word and a shared freeze word. An increment strobe per counter comes from event qualification logic outside the block. That logic is also the consumer of the event mask, group index and filter value stored here.

When an enabled, unfrozen counter passes its all-ones value, it wraps to zero and latches its overflow status bit. Per-counter options can also freeze that counter, and can raise the single level interrupt output. Software handles an overflow as follows: it reads the overflow word, reads the counters, writes the read bits back to clear them, and reloads counters. Counters accept writes while frozen.

The register offsets are fixed, because software decodes them. Capability word at 0x000, overflow word at 0x010, freeze word at 0x018, event-capability word k at 0x100+8k, configuration of counter n at 0x200+8n, filter of counter n at 0x400+8n, count of counter n at 0xC00+8n. Address bits 2:0 are ignored.

Top module: `pmc_bank`

## Requirements
- R1: The capability word is constant. It holds NUM_CTR-1 in bits 5:0, CTR_W in bits 15:8, NUM_EVCAP-1 in bits 24:20, FILTERS in bits 39:32, IRQ_MSG in bits 47:44, ones in bits 50:48 (write-while-frozen, freeze, interrupt) and VERSION in bits 63:60. All other bits are zero.
- R2: Event-capability word k (k < NUM_EVCAP) reads as {VENDOR_ID[63:48], GRP_BASE+k [47:32], EVT_SUPPORT[31:0]}.
- R3: A counter with enable (configuration bit 8) set and its freeze bit clear adds one on every clock edge where its increment strobe is high. A disabled counter holds its value.
- R4: Writing the freeze word loads bits NUM_CTR-1:0 and ignores higher bits, which read zero. A counter whose freeze bit is set holds its value.
- R5: A count register write loads the written value, also while the counter is frozen. It takes precedence over a same-cycle increment.
- R6: An increment at the all-ones value wraps the counter to zero and sets its overflow status bit on the same edge.
- R7: If freeze-on-overflow (configuration bit 10) is set, a wrap also sets that counter's freeze bit on the same edge. Otherwise the freeze bit is untouched.
- R8: irq is high exactly while some overflow bit is set whose counter has interrupt-on-overflow (configuration bit 9) set. It drops once those bits are cleared.
- R9: Writing the overflow word clears each bit written as one and keeps each bit written as zero. An overflow occurring in the same cycle as the write keeps its bit set.
- R10: Configuration bits 1:0 read the counter kind (0 free-running, 1 fixed-function, 2 configurable) and ignore writes. Writable fields are bits 10:8, the event mask in bits 55:24 and the group index in bits 63:59. On fixed-function counters, the mask and group index read constant values and ignore writes. All other bits read zero.
- R11: A filter register keeps a 32-bit value in bits 31:0, resets to all ones, and reads zero in bits 63:32.
- R12: Read data appears with rd_valid one cycle after rd_en. Reads of unimplemented counter or capability indices, and of unmapped offsets, return zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| evt_inc | input | NUM_CTR | Per-counter increment strobes |
| irq | output | 1 | Overflow interrupt level |

## Verification
The assertions assume that each increment strobe means at most one event per cycle. They also assume that a count write and an increment of the same counter may coincide, and that software never depends on a read issued in the same cycle as a write. The stimulus changes inputs only on the falling clock edge. It never asserts rd_en and wr_en together. It places simultaneous write-and-event cycles only where a requirement defines who wins: the count load and the overflow clear.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_CAP, SEL_OVF, SEL_FRZ, SEL_EVCAP, SEL_CFG, SEL_FLT, SEL_CNT
  } reg_sel_e;

  localparam int CFG_EN_BIT   = 8;
  localparam int CFG_INT_BIT  = 9;
  localparam int CFG_FRZ_BIT  = 10;
  localparam int CFG_MASK_LSB = 24;
  localparam int CFG_GRP_LSB  = 59;

  localparam logic [1:0] KIND_FREE  = 2'd0;
  localparam logic [1:0] KIND_FIXED = 2'd1;
  localparam logic [1:0] KIND_CONF  = 2'd2;
endpackage

// File: rtl/pmc_decode.sv
module pmc_decode
  import pmc_pkg::*;
(
  input  logic [11:0] addr,
  output reg_sel_e    sel,
  output logic [5:0]  idx
);
  logic unused_lsb;
  assign unused_lsb = ^addr[2:0];

  always_comb begin
    sel = SEL_NONE;
    idx = addr[8:3];
    case (addr[11:9])
      3'b000: begin
        if (addr[8]) begin
          sel = SEL_EVCAP;
          idx = {1'b0, addr[7:3]};
        end else if (addr[7:3] == 5'd0) begin
          sel = SEL_CAP;
        end else if (addr[7:3] == 5'd2) begin
          sel = SEL_OVF;
        end else if (addr[7:3] == 5'd3) begin
          sel = SEL_FRZ;
        end
      end
      3'b001:  sel = SEL_CFG;
      3'b010:  sel = SEL_FLT;
      3'b110:  sel = SEL_CNT;
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
  import pmc_pkg::*;
#(
  parameter int          CTR_W      = 16,
  parameter logic [1:0]  KIND       = KIND_CONF,
  parameter logic [31:0] FIXED_MASK = 32'h0000_0001,
  parameter logic [4:0]  FIXED_GRP  = 5'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             flt_we,
  input  logic             cnt_we,
  input  logic [63:0]      wdata,
  input  logic             inc,
  input  logic             frozen,
  output logic [63:0]      cfg_rd,
  output logic [31:0]      flt_rd,
  output logic [CTR_W-1:0] cnt_rd,
  output logic             en,
  output logic             int_en,
  output logic             frz_en,
  output logic             wrap
);
  logic             en_q, int_q, frzo_q;
  logic [31:0]      evm;
  logic [4:0]       grp;
  logic [31:0]      flt_q;
  logic [CTR_W-1:0] cnt_q, cnt_d;
  logic             live;
  logic             unused_wd;

  assign unused_wd = ^wdata;
  assign live = inc && en_q && !frozen;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we)    cnt_d = wdata[CTR_W-1:0];
    else if (live) cnt_d = cnt_q + 1'b1;
  end

  assign wrap = live && !cnt_we && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      int_q  <= 1'b0;
      frzo_q <= 1'b0;
    end else if (cfg_we) begin
      en_q   <= wdata[CFG_EN_BIT];
      int_q  <= wdata[CFG_INT_BIT];
      frzo_q <= wdata[CFG_FRZ_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flt_q <= '1;
    else if (flt_we) flt_q <= wdata[31:0];
  end

  generate
    if (KIND == KIND_FIXED) begin : g_fixed
      assign evm = FIXED_MASK;
      assign grp = FIXED_GRP;
    end else begin : g_prog
      logic [31:0] evm_q;
      logic [4:0]  grp_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          evm_q <= '0;
          grp_q <= '0;
        end else if (cfg_we) begin
          evm_q <= wdata[CFG_MASK_LSB +: 32];
          grp_q <= wdata[CFG_GRP_LSB +: 5];
        end
      end
      assign evm = evm_q;
      assign grp = grp_q;
    end
  endgenerate

  assign cfg_rd = {grp, 3'b000, evm, 13'd0, frzo_q, int_q, en_q, 6'd0, KIND};
  assign flt_rd = flt_q;
  assign cnt_rd = cnt_q;
  assign en     = en_q;
  assign int_en = int_q;
  assign frz_en = frzo_q;

  assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !cnt_we) |=> $stable(cnt_q));
  assert_disabled_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_we) |=> $stable(cnt_q));
  assert_write_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(wdata[CTR_W-1:0])));
endmodule

// File: rtl/pmc_status.sv
module pmc_status #(
  parameter int NUM_CTR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ovf_we,
  input  logic               frz_we,
  input  logic [NUM_CTR-1:0] wbits,
  input  logic [NUM_CTR-1:0] wrap,
  input  logic [NUM_CTR-1:0] frz_en,
  input  logic [NUM_CTR-1:0] int_en,
  output logic [NUM_CTR-1:0] ovf,
  output logic [NUM_CTR-1:0] frz,
  output logic               irq
);
  logic [NUM_CTR-1:0] ovf_q, ovf_d, frz_q, frz_d;

  always_comb begin
    ovf_d = ovf_q;
    if (ovf_we) ovf_d = ovf_q & ~wbits;
    ovf_d = ovf_d | wrap;
    frz_d = frz_we ? wbits : frz_q;
    frz_d = frz_d | (wrap & frz_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
      frz_q <= '0;
    end else begin
      ovf_q <= ovf_d;
      frz_q <= frz_d;
    end
  end

  assign ovf = ovf_q;
  assign frz = frz_q;
  assign irq = |(ovf_q & int_en);

  generate
    for (genvar n = 0; n < NUM_CTR; n++) begin : g_chk
      assert_wrap_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[n] |=> ovf_q[n]);
      assert_wrap_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap[n] && frz_en[n]) |=> frz_q[n]);
      assert_clear_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_q[n]) |-> $past(ovf_we && wbits[n]));
    end
  endgenerate
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int                  NUM_CTR     = 4,
  parameter int                  CTR_W       = 16,
  parameter int                  NUM_EVCAP   = 2,
  parameter logic [2*NUM_CTR-1:0] CTR_KIND   = 8'b10_10_01_00,
  parameter logic [31:0]         FIXED_MASK  = 32'h0000_0001,
  parameter logic [4:0]          FIXED_GRP   = 5'd0,
  parameter logic [15:0]         VENDOR_ID   = 16'hABCD,
  parameter logic [15:0]         GRP_BASE    = 16'h0010,
  parameter logic [31:0]         EVT_SUPPORT = 32'h0000_00FF,
  parameter logic [7:0]          FILTERS     = 8'h01,
  parameter logic [3:0]          IRQ_MSG     = 4'd3,
  parameter logic [3:0]          VERSION     = 4'd1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [11:0]        addr,
  input  logic [63:0]        wdata,
  output logic [63:0]        rdata,
  output logic               rd_valid,
  input  logic [NUM_CTR-1:0] evt_inc,
  output logic               irq
);
  localparam logic [63:0] CAP_WORD = {VERSION, 9'd0, 3'b111, IRQ_MSG, 4'd0, FILTERS,
                                      7'd0, 5'(NUM_EVCAP-1), 4'd0, 8'(CTR_W),
                                      2'd0, 6'(NUM_CTR-1)};
  localparam int PAD_W = 64 - CTR_W;

  reg_sel_e           sel;
  logic [5:0]         idx;
  logic [NUM_CTR-1:0] wrap, frz_en, int_en, en_v, ovf, frz;
  logic [63:0]        cfg_rd [NUM_CTR];
  logic [31:0]        flt_rd [NUM_CTR];
  logic [CTR_W-1:0]   cnt_rd [NUM_CTR];
  logic [63:0]        rdata_d, rdata_q;
  logic               rvalid_q;
  logic               unused_en;

  assign unused_en = ^en_v;

  pmc_decode u_dec (.addr(addr), .sel(sel), .idx(idx));

  generate
    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
      logic hit;
      assign hit = wr_en && (idx == 6'(n));
      pmc_counter #(
        .CTR_W(CTR_W), .KIND(CTR_KIND[2*n +: 2]),
        .FIXED_MASK(FIXED_MASK), .FIXED_GRP(FIXED_GRP)
      ) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(hit && sel == SEL_CFG),
        .flt_we(hit && sel == SEL_FLT),
        .cnt_we(hit && sel == SEL_CNT),
        .wdata(wdata), .inc(evt_inc[n]), .frozen(frz[n]),
        .cfg_rd(cfg_rd[n]), .flt_rd(flt_rd[n]), .cnt_rd(cnt_rd[n]),
        .en(en_v[n]), .int_en(int_en[n]), .frz_en(frz_en[n]), .wrap(wrap[n])
      );
    end
  endgenerate

  pmc_status #(.NUM_CTR(NUM_CTR)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .ovf_we(wr_en && sel == SEL_OVF),
    .frz_we(wr_en && sel == SEL_FRZ),
    .wbits(wdata[NUM_CTR-1:0]),
    .wrap(wrap), .frz_en(frz_en), .int_en(int_en),
    .ovf(ovf), .frz(frz), .irq(irq)
  );

  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_CAP: rdata_d = CAP_WORD;
      SEL_OVF: rdata_d = 64'(ovf);
      SEL_FRZ: rdata_d = 64'(frz);
      SEL_EVCAP: begin
        for (int k = 0; k < NUM_EVCAP; k++)
          if (idx == 6'(k)) rdata_d = {VENDOR_ID, GRP_BASE + 16'(k), EVT_SUPPORT};
      end
      SEL_CFG: begin
        for (int k = 0; k < NUM_CTR; k++)
          if (idx == 6'(k)) rdata_d = cfg_rd[k];
      end
      SEL_FLT: begin
        for (int k = 0; k < NUM_CTR; k++)
          if (idx == 6'(k)) rdata_d = {32'd0, flt_rd[k]};
      end
      SEL_CNT: begin
        for (int k = 0; k < NUM_CTR; k++)
          if (idx == 6'(k)) rdata_d = {{PAD_W{1'b0}}, cnt_rd[k]};
      end
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rvalid_q;

  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf != '0));
endmodule

// File: tb/pmc_bank_test.sv
module pmc_bank_test;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [11:0]   addr;
  logic [63:0]   wdata;
  logic [63:0]   rdata;
  logic          rd_valid;
  logic [NC-1:0] evt_inc;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  pmc_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .evt_inc(evt_inc), .irq(irq)
  );

  function automatic logic [11:0] a_cfg(int n); return 12'(12'h200 + 8*n); endfunction
  function automatic logic [11:0] a_flt(int n); return 12'(12'h400 + 8*n); endfunction
  function automatic logic [11:0] a_cnt(int n); return 12'(12'hC00 + 8*n); endfunction
  function automatic logic [11:0] a_evc(int n); return 12'(12'h100 + 8*n); endfunction
  localparam logic [11:0] A_OVF = 12'h010;
  localparam logic [11:0] A_FRZ = 12'h018;

  // monitor: pops expected read data as results come out
  always @(negedge clk) begin
    if (rd_valid && rst_n) begin
      logic [63:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R12 unexpected read data got %h exp none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s got %h exp %h", t, rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [63:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_inc(input logic [11:0] a, input logic [63:0] d, input int n);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; evt_inc[n] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; evt_inc[n] = 1'b0;
  endtask

  task automatic pulse(input int n, input int k);
    @(negedge clk);
    evt_inc[n] = 1'b1;
    repeat (k) @(negedge clk);
    evt_inc[n] = 1'b0;
  endtask

  task automatic chk(input string t, input logic got, input logic e);
    checks++;
    if (got !== e) begin
      failures++;
      $display("FAIL %s got %b exp %b", t, got, e);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired got running exp finished");
      finish_run();
    end
  end

  initial begin
    logic [63:0] cap;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; evt_inc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R8 irq low after reset", irq, 1'b0);
    chk("R12 rd_valid idle", rd_valid, 1'b0);
    cap = (64'd1 << 60) | (64'd7 << 48) | (64'd3 << 44) | (64'h01 << 32)
        | (64'd1 << 20) | (64'd16 << 8) | 64'd3;
    rd(12'h000, cap, "R1 capability word");
    rd(a_evc(0), {16'hABCD, 16'h0010, 32'h0000_00FF}, "R2 event cap 0");
    rd(a_evc(1), {16'hABCD, 16'h0011, 32'h0000_00FF}, "R2 event cap 1");
    rd(a_evc(2), 64'd0, "R12 event cap beyond count");
    rd(A_OVF, 64'd0, "R9 overflow reset");
    rd(A_FRZ, 64'd0, "R4 freeze reset");
    rd(a_cfg(0), 64'd0, "R10 cfg0 free-running reset");
    rd(a_cfg(1), (64'd1 << 24) | 64'd1, "R10 cfg1 fixed reset");
    rd(a_cfg(2), 64'd2, "R10 cfg2 configurable reset");
    rd(a_flt(0), 64'h0000_0000_FFFF_FFFF, "R11 filter reset");
    rd(a_cnt(0), 64'd0, "R3 count reset");

    // R10 writable vs read-only fields
    wr(a_cfg(2), (64'd3 << 59) | (64'd5 << 24) | (64'd1 << 20) | (64'd1 << 8) | (64'd1 << 4));
    rd(a_cfg(2), (64'd3 << 59) | (64'd5 << 24) | (64'd1 << 8) | 64'd2, "R10 cfg2 fields");
    wr(a_cfg(1), '1);
    rd(a_cfg(1), (64'd1 << 24) | (64'd7 << 8) | 64'd1, "R10 cfg1 fixed fields read-only");

    // R3 counting
    pulse(2, 5);
    rd(a_cnt(2), 64'd5, "R3 enabled counter adds events");
    pulse(3, 5);
    rd(a_cnt(3), 64'd0, "R3 disabled counter holds");

    // R4 freeze, R5 write while frozen
    wr(A_FRZ, '1);
    rd(A_FRZ, 64'hF, "R4 freeze word width");
    pulse(2, 3);
    rd(a_cnt(2), 64'd5, "R4 frozen counter holds");
    wr(a_cnt(2), 64'd0);
    rd(a_cnt(2), 64'd0, "R5 write while frozen");
    wr(a_cnt(2), 64'hFFFD);
    wr(A_FRZ, 64'd0);
    rd(A_FRZ, 64'd0, "R4 freeze released");

    // R6 R7 R8 wrap with freeze and interrupt
    wr(a_cfg(2), 64'd7 << 8);
    pulse(2, 4);
    rd(a_cnt(2), 64'd0, "R6 wrap to zero then frozen");
    rd(A_OVF, 64'h4, "R6 overflow bit set");
    rd(A_FRZ, 64'h4, "R7 freeze on overflow");
    chk("R8 irq raised", irq, 1'b1);

    // R9 write-one-to-clear
    wr(A_OVF, 64'd0);
    rd(A_OVF, 64'h4, "R9 zero write keeps bit");
    chk("R8 irq held", irq, 1'b1);
    wr(A_OVF, 64'h4);
    rd(A_OVF, 64'd0, "R9 one write clears bit");
    chk("R8 irq dropped", irq, 1'b0);

    // wrap without interrupt or freeze option
    wr(a_cfg(0), 64'd1 << 8);
    wr(a_cnt(0), 64'hFFFF);
    pulse(0, 1);
    rd(A_OVF, 64'h1, "R6 free-running wrap");
    chk("R8 irq stays low without int enable", irq, 1'b0);
    rd(A_FRZ, 64'h4, "R7 no freeze without option");

    // R9 same-cycle set wins
    wr(a_cnt(0), 64'hFFFF);
    wr_inc(A_OVF, 64'h1, 0);
    rd(A_OVF, 64'h1, "R9 overflow in clear cycle stays set");
    wr(A_OVF, 64'h1);
    rd(A_OVF, 64'd0, "R9 cleared after");

    // R5 write beats increment
    wr(A_FRZ, 64'd0);
    wr_inc(a_cnt(2), 64'h100, 2);
    rd(a_cnt(2), 64'h100, "R5 write wins over increment");

    // R11 filter, R12 unimplemented
    wr(a_flt(1), 64'hDEAD_BEEF_1234_5678);
    rd(a_flt(1), 64'h0000_0000_1234_5678, "R11 filter low half kept");
    wr(a_cfg(5), '1);
    rd(a_cfg(5), 64'd0, "R12 unimplemented cfg reads zero");
    wr(a_cnt(6), 64'h55);
    rd(a_cnt(6), 64'd0, "R12 unimplemented count reads zero");
    rd(a_cnt(1), 64'd0, "R12 neighbour count untouched");
    rd(12'h020, 64'd0, "R12 unmapped offset");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R12 missing read results got %0d pending exp 0", exp_q.size());
    end
    done = 1;
    finish_run();
  end
endmodule